// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt state of a packet-oriented network controller. It holds an 8-bit status register and an 8-bit mask register, and it drives one level-sensitive interrupt line. Single-cycle event pulses from the datapath set status bits, for example when a frame arrives or when a transmit buffer is granted. Two further bits follow queue occupancy: they are forced on in every cycle in which the transmit queue is empty or the transmit-completion queue holds an entry.

Software reads the status and mask, writes the mask, and writes an acknowledge byte. The acknowledge byte clears only the bits that software is allowed to clear. An acknowledge with the transmit-complete bit set also sends a one-cycle pop strobe to the completion queue. The bus decoder, the queues and the event sources sit outside this block.

Top module: `irq_status_ctrl`

## Requirements
- R1: The status bits are laid out as follows. Bit 7 is management, bit 6 is early receive, bit 5 is PHY event, bit 4 is receive overrun, bit 3 is allocation done, bit 2 is TX empty, bit 1 is TX complete and bit 0 is receive. Bit k of `evt_set` sets status bit k.
- R2: `irq_o` is high exactly when `status_o & mask_o` is nonzero. It changes on the same clock edge as the registers it depends on.
- R3: In every cycle in which `txq_empty` is high, status bit 2 is set at the next edge, even when the same cycle acknowledges that bit.
- R4: In every cycle in which `done_nonempty` is high, status bit 1 is set at the next edge, even when the same cycle acknowledges that bit.
- R5: An acknowledge (`ack_we` high) clears, at the next edge, each status bit written as 1 that lies within mask 0xD6 (bits 7, 6, 4, 2, 1).
- R6: Acknowledge bits 5, 3 and 0 have no effect. Only reset clears those status bits.
- R7: An acknowledge with bit 1 set produces `done_pop_o` high for exactly the one cycle after the write. Otherwise `done_pop_o` stays low.
- R8: While reset is active, and right after it, status is 0x04, mask is 0x00, and both `irq_o` and `done_pop_o` are low.
- R9: A mask write loads `mask_data` into `mask_o` at the next edge, and `irq_o` reflects the new mask at that same edge.
- R10: When an event pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R11: An event-set status bit stays set until it is acknowledged or the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 8 | One-cycle event pulses, one per status bit |
| txq_empty | input | 1 | Transmit queue length is zero |
| done_nonempty | input | 1 | Transmit-completion queue holds at least one entry |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Acknowledge byte; a 1 requests a clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask value |
| status_o | output | 8 | Interrupt status register |
| mask_o | output | 8 | Interrupt mask register |
| irq_o | output | 1 | Level interrupt request |
| done_pop_o | output | 1 | One-cycle pop strobe to the completion queue |

## Verification
A corrupted status bit shows up on `status_o` one edge after the stimulus that caused it. If that bit is unmasked, it also shows up on `irq_o` at the same edge. A wrong clear decode can leave a bit stuck, and a wrong priority between set and clear can lose an event. Either fault appears on the next read of the status after a combined acknowledge-and-event cycle. A broken pop path shows as a missing or stray `done_pop_o` pulse in the single cycle that follows the acknowledge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_MGMT = 7;
    localparam int BIT_ERX  = 6;
    localparam int BIT_PHY  = 5;
    localparam int BIT_OVR  = 4;
    localparam int BIT_ALOC = 3;
    localparam int BIT_TXE  = 2;
    localparam int BIT_TXC  = 1;
    localparam int BIT_RCV  = 0;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic              irq;
        logic              pop;
    } ctrl_state_t;

endpackage

// File: rtl/irq_clear_decode.sv
module irq_clear_decode #(
    parameter int              W        = 8,
    parameter logic [W-1:0]    ACK_MASK = 8'hD6,
    parameter int              POP_BIT  = 1
) (
    input  logic         ack_we,
    input  logic [W-1:0] ack_data,
    output logic [W-1:0] clr_vec,
    output logic         pop_req
);

    always_comb begin
        clr_vec = ack_we ? (ack_data & ACK_MASK) : '0;
        pop_req = ack_we & ack_data[POP_BIT];
    end

endmodule

// File: rtl/irq_status_next.sv
module irq_status_next #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] nxt
);

    // Per bit: the set sources (pulse or level) take priority over clear.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i] = (cur[i] & ~clr[i]) | evt[i] | lvl[i];
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter logic [STAT_W-1:0] ACK_MASK   = 8'hD6,
    parameter logic [STAT_W-1:0] RST_STATUS = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_set,
    input  logic              txq_empty,
    input  logic              done_nonempty,
    input  logic              ack_we,
    input  logic [STAT_W-1:0] ack_data,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_data,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o,
    output logic              done_pop_o
);

    ctrl_state_t       state_d, state_q;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] lvl_vec;
    logic [STAT_W-1:0] stat_nxt;
    logic              pop_req;

    irq_clear_decode #(
        .W        (STAT_W),
        .ACK_MASK (ACK_MASK),
        .POP_BIT  (BIT_TXC)
    ) u_clr (
        .ack_we   (ack_we),
        .ack_data (ack_data),
        .clr_vec  (clr_vec),
        .pop_req  (pop_req)
    );

    always_comb begin
        lvl_vec          = '0;
        lvl_vec[BIT_TXE] = txq_empty;
        lvl_vec[BIT_TXC] = done_nonempty;
    end

    irq_status_next #(
        .W (STAT_W)
    ) u_next (
        .cur (state_q.status),
        .clr (clr_vec),
        .evt (evt_set),
        .lvl (lvl_vec),
        .nxt (stat_nxt)
    );

    always_comb begin
        state_d        = state_q;
        state_d.status = stat_nxt;
        state_d.mask   = mask_we ? mask_data : state_q.mask;
        state_d.irq    = |(state_d.status & state_d.mask);
        state_d.pop    = pop_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.status <= RST_STATUS;
            state_q.mask   <= '0;
            state_q.irq    <= 1'b0;
            state_q.pop    <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o   = state_q.status;
    assign mask_o     = state_q.mask;
    assign irq_o      = state_q.irq;
    assign done_pop_o = state_q.pop;

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
    parameter int           W        = 8,
    parameter logic [W-1:0] ACK_MASK = 8'hD6,
    parameter int           TXE_BIT  = 2,
    parameter int           TXC_BIT  = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_set,
    input logic         txq_empty,
    input logic         done_nonempty,
    input logic         ack_we,
    input logic [W-1:0] ack_data,
    input logic         mask_we,
    input logic [W-1:0] mask_data,
    input logic [W-1:0] status_o,
    input logic [W-1:0] mask_o,
    input logic         irq_o,
    input logic         done_pop_o
);

    p_irq_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(status_o & mask_o)));

    p_txe_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty |=> status_o[TXE_BIT]);

    p_txc_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_nonempty |=> status_o[TXC_BIT]);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && evt_set == '0 && !txq_empty && !done_nonempty)
        |=> ((status_o & $past(ack_data) & ACK_MASK) == '0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_o) & ~ACK_MASK) & ~status_o) == '0));

    p_pop_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_data[TXC_BIT]) |=> done_pop_o);

    p_pop_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_we && ack_data[TXC_BIT]) |=> !done_pop_o);

    p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(mask_data)));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((status_o & $past(evt_set)) == $past(evt_set)));

endmodule

bind irq_status_ctrl irq_status_chk #(
    .W        (irq_ctrl_pkg::STAT_W),
    .ACK_MASK (ACK_MASK),
    .TXE_BIT  (irq_ctrl_pkg::BIT_TXE),
    .TXC_BIT  (irq_ctrl_pkg::BIT_TXC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_set       (evt_set),
    .txq_empty     (txq_empty),
    .done_nonempty (done_nonempty),
    .ack_we        (ack_we),
    .ack_data      (ack_data),
    .mask_we       (mask_we),
    .mask_data     (mask_data),
    .status_o      (status_o),
    .mask_o        (mask_o),
    .irq_o         (irq_o),
    .done_pop_o    (done_pop_o)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 18;

    typedef struct packed {
        logic [7:0] evt;
        logic       txe;
        logic       dne;
        logic       awe;
        logic [7:0] ack;
        logic       mwe;
        logic [7:0] msk;
        logic [7:0] e_stat;
        logic [7:0] e_mask;
        logic       e_irq;
        logic       e_pop;
    } vec_t;

    // Rows run in sequence from the reset state (status 04, mask 00).
    localparam vec_t TBL [NVEC] = '{
        '{8'h01,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 8'h05,8'h00,1'b0,1'b0}, // R11 event sets bit 0
        '{8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,8'hFF, 8'h05,8'hFF,1'b1,1'b0}, // R9 R2
        '{8'h00,1'b0,1'b0,1'b1,8'hFF,1'b0,8'h00, 8'h01,8'hFF,1'b1,1'b1}, // R5 R6 R7
        '{8'h28,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 8'h29,8'hFF,1'b1,1'b0}, // R1
        '{8'h00,1'b0,1'b0,1'b1,8'h29,1'b0,8'h00, 8'h29,8'hFF,1'b1,1'b0}, // R6
        '{8'hD0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00, 8'hF9,8'hFF,1'b1,1'b0}, // R1 R11
        '{8'h00,1'b0,1'b0,1'b1,8'h90,1'b0,8'h00, 8'h69,8'hFF,1'b1,1'b0}, // R5
        '{8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,8'h10, 8'h69,8'h10,1'b0,1'b0}, // R2 R9
        '{8'h10,1'b0,1'b0,1'b1,8'h10,1'b0,8'h00, 8'h79,8'h10,1'b1,1'b0}, // R10
        '{8'h00,1'b0,1'b0,1'b1,8'h10,1'b0,8'h00, 8'h69,8'h10,1'b0,1'b0}, // R5 R2
        '{8'h00,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00, 8'h6D,8'h10,1'b0,1'b0}, // R3
        '{8'h00,1'b1,1'b0,1'b1,8'h04,1'b0,8'h00, 8'h6D,8'h10,1'b0,1'b0}, // R3 level beats ack
        '{8'h00,1'b0,1'b0,1'b1,8'h04,1'b0,8'h00, 8'h69,8'h10,1'b0,1'b0}, // R5
        '{8'h00,1'b0,1'b1,1'b0,8'h00,1'b0,8'h00, 8'h6B,8'h10,1'b0,1'b0}, // R4
        '{8'h00,1'b0,1'b1,1'b1,8'h02,1'b0,8'h00, 8'h6B,8'h10,1'b0,1'b1}, // R4 R7
        '{8'h00,1'b0,1'b0,1'b1,8'h02,1'b0,8'h00, 8'h69,8'h10,1'b0,1'b1}, // R5 R7
        '{8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,8'h02, 8'h69,8'h02,1'b0,1'b0}, // R9 R2
        '{8'h00,1'b0,1'b0,1'b0,8'h00,1'b1,8'h01, 8'h69,8'h01,1'b1,1'b0}  // R9 R2
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_set;
    logic       txq_empty;
    logic       done_nonempty;
    logic       ack_we;
    logic [7:0] ack_data;
    logic       mask_we;
    logic [7:0] mask_data;
    logic [7:0] status_o;
    logic [7:0] mask_o;
    logic       irq_o;
    logic       done_pop_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_set       (evt_set),
        .txq_empty     (txq_empty),
        .done_nonempty (done_nonempty),
        .ack_we        (ack_we),
        .ack_data      (ack_data),
        .mask_we       (mask_we),
        .mask_data     (mask_data),
        .status_o      (status_o),
        .mask_o        (mask_o),
        .irq_o         (irq_o),
        .done_pop_o    (done_pop_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_set = '0; txq_empty = 1'b0; done_nonempty = 1'b0;
        ack_we = 1'b0; ack_data = '0; mask_we = 1'b0; mask_data = '0;
    endtask

    task automatic check_reset_state(input string tag);
        check(tag, "status", status_o, 8'h04);
        check(tag, "mask", mask_o, 8'h00);
        check(tag, "irq", {7'd0, irq_o}, 8'h00);
        check(tag, "pop", {7'd0, done_pop_o}, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset_state("R8 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("R8 after reset");

        // Table walk: drive at the falling edge, check after the next rising edge.
        for (int i = 0; i < NVEC; i++) begin
            evt_set       = TBL[i].evt;
            txq_empty     = TBL[i].txe;
            done_nonempty = TBL[i].dne;
            ack_we        = TBL[i].awe;
            ack_data      = TBL[i].ack;
            mask_we       = TBL[i].mwe;
            mask_data     = TBL[i].msk;
            @(negedge clk);
            check($sformatf("row %0d R1/R5/R10 status", i), "status", status_o, TBL[i].e_stat);
            check($sformatf("row %0d R9 mask", i), "mask", mask_o, TBL[i].e_mask);
            check($sformatf("row %0d R2 irq", i), "irq", {7'd0, irq_o}, {7'd0, TBL[i].e_irq});
            check($sformatf("row %0d R7 pop", i), "pop", {7'd0, done_pop_o}, {7'd0, TBL[i].e_pop});
        end
        idle_inputs();

        // R7: the pop strobe lasts only one cycle.
        @(negedge clk);
        check("R7 single cycle", "pop", {7'd0, done_pop_o}, 8'h00);

        // R11: an event bit holds with no further stimulus.
        repeat (3) @(negedge clk);
        check("R11 hold", "status", status_o, 8'h69);

        // R8: a mid-run reset restores the initial state.
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R8 mid-run");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: each event input sets its own bit position.
        for (int k = 0; k < 8; k++) begin
            evt_set = 8'(1 << k);
            @(negedge clk);
            evt_set = '0;
            check("R1 bit position", "status", status_o,
                  8'h04 | 8'((1 << (k + 1)) - 1));
        end

        // R6: non-clearable bits stay set through a full acknowledge.
        ack_we = 1'b1; ack_data = 8'hFF;
        @(negedge clk);
        idle_inputs();
        check("R6 keep 0x29", "status", status_o, 8'h29);

        finish_run();
    end

endmodule